// File: doc/BRIEF.md
# Clock-Enable Configuration Slave (Two-Wire Write-Only)

This block is the configuration port of a clock generator. It listens on a two-wire serial bus (SCL and SDA) and stores a small bank of 8-bit control registers. Those registers gate the individual clock outputs and select how spread spectrum is applied. The slave only accepts writes. A master opens a transfer with a START condition. It then sends the device address with the write direction, followed by two bytes that the slave acknowledges and discards: a command byte and a count byte. Every byte after those two is stored in order, starting at register 0.

Both bus lines are oversampled in the system clock domain through two-flop synchronizers. The slave pulls SDA low by raising `sda_oe` during the ninth SCL pulse of each byte it accepts. An external open-drain pad turns that request into a low level on SDA. Register defaults come back only from the power-on reset input `rst_n`. Bus events such as STOP or a repeated START never restore them.

Top module: `clkcfg_slave`

## Requirements
- R1: While and after `rst_n` is low, the register image reads 0x07, 0xFF, 0xFE, 0x00, 0x00, 0x00 for registers 0 to 5. Register i sits at `cfg_image[8*i+7:8*i]`.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Either one abandons the byte in progress without writing it. A START begins a new address phase.
- R3: An address byte equal to {DEV_ADDR, 1'b0} is acknowledged. `sda_oe` is 1 while SCL is high in the ninth pulse and returns to 0 once that pulse's SCL falls.
- R4: An address byte with another address, or with bit 0 = 1 (read), is not acknowledged. No later byte is acknowledged or stored until the next START.
- R5: The two bytes after an accepted address (command, then count) are acknowledged and change no register, whatever their values.
- R6: Data bytes are received MSB first and written to registers 0, 1, 2, ... in arrival order. Each is acknowledged.
- R7: Data bytes beyond register 5 are acknowledged and leave every register unchanged.
- R8: Outputs follow the registers, with 1 meaning enabled: `aux_clk_en` = reg0[2:0], `ssc_en` = reg0[3], `sdram_clk_en` = reg1, `pci_clk_en` = reg2. `spread_center` = reg5[7], where 1 selects centre spread and 0 selects down spread.
- R9: A STOP or a START leaves stored values as they are. Only `rst_n` reloads the defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Power-on reset, active low; loads register defaults |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 requests the pad to pull SDA low (acknowledge) |
| aux_clk_en | output | 3 | Enables for the three auxiliary clocks (reg0[2:0]) |
| ssc_en | output | 1 | Spread-spectrum on (reg0[3]) |
| sdram_clk_en | output | 8 | Memory clock enables (reg1) |
| pci_clk_en | output | 8 | Peripheral bus clock enables (reg2) |
| spread_center | output | 1 | Spread profile: 1 centre, 0 down (reg5[7]) |
| cfg_image | output | 48 | Whole register bank, register i in bits 8*i+7..8*i |

## Verification
Every bus edge crosses two synchronizer flops and one state register. As a result:
- A register write appears three system clocks after the SCL rise that carries the byte's eighth bit.
- `sda_oe` rises three clocks after the eighth-bit SCL fall.
- `sda_oe` drops three clocks after the ninth-pulse fall.

The bench holds each SCL half-period for 12 clocks. It samples the acknowledge six clocks into the ninth high phase. It checks release six clocks after the following fall, and it compares register outputs only after the STOP has settled. Every sample therefore lands well after its result is due and before the next bus edge can disturb it.

// File: rtl/clkcfg_pkg.sv
`timescale 1ns/1ps
package clkcfg_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA,
        PH_SKIP
    } phase_e;

    // power-on value of each register in the bank
    function automatic logic [BYTE_W-1:0] reg_default(input int unsigned idx);
        case (idx)
            0:       return 8'h07;
            1:       return 8'hFF;
            2:       return 8'hFE;
            default: return 8'h00;
        endcase
    endfunction

    // phase entered after the acknowledge slot of an accepted byte
    function automatic phase_e phase_after(input phase_e cur);
        case (cur)
            PH_ADDR: return PH_CMD;
            PH_CMD:  return PH_CNT;
            PH_CNT:  return PH_DATA;
            PH_DATA: return PH_DATA;
            default: return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/clkcfg_sync.sv
`timescale 1ns/1ps
module clkcfg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int unsigned LINES = 2;
    localparam int unsigned DEPTH = STAGES + 1;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [DEPTH-1:0] pipe_d;
        logic [DEPTH-1:0] pipe_q;

        always_comb begin
            pipe_d = {pipe_q[DEPTH-2:0], raw[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= pipe_d;
        end

        assign cur[g]  = pipe_q[STAGES-1];
        assign prev[g] = pipe_q[STAGES];
    end

    assign scl_s     = cur[0];
    assign sda_s     = cur[1];
    assign scl_rise  = cur[0] & ~prev[0];
    assign scl_fall  = ~cur[0] & prev[0];
    assign start_det = cur[0] & prev[0] & prev[1] & ~cur[1];
    assign stop_det  = cur[0] & prev[0] & ~prev[1] & cur[1];

endmodule

// File: rtl/clkcfg_bus_fsm.sv
`timescale 1ns/1ps
module clkcfg_bus_fsm
    import clkcfg_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h69,
    parameter int unsigned NREG     = 6,
    localparam int unsigned PW      = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output phase_e            phase,
    output logic [PW-1:0]     ptr,
    output logic              wr_en,
    output logic [PW-1:0]     wr_idx,
    output logic [BYTE_W-1:0] wr_data
);
    localparam logic [PW-1:0]     PTR_END  = PW'(NREG);
    localparam logic [BYTE_W-1:0] ADDR_WR  = {DEV_ADDR, 1'b0};

    typedef struct packed {
        phase_e            phase;
        logic [2:0]        bit_cnt;
        logic [BYTE_W-1:0] shreg;
        logic              wait_ack;
        logic              in_ack;
        logic              oe;
        logic [PW-1:0]     ptr;
    } fsm_t;

    fsm_t st_d;
    fsm_t st_q;
    logic [BYTE_W-1:0] next_byte;
    logic              active;

    always_comb begin
        st_d      = st_q;
        wr_en     = 1'b0;
        wr_idx    = st_q.ptr;
        next_byte = {st_q.shreg[BYTE_W-2:0], sda_s};
        wr_data   = next_byte;
        active    = (st_q.phase == PH_ADDR) || (st_q.phase == PH_CMD) ||
                    (st_q.phase == PH_CNT)  || (st_q.phase == PH_DATA);

        if (start_det || stop_det) begin
            st_d.phase    = start_det ? PH_ADDR : PH_IDLE;
            st_d.bit_cnt  = '0;
            st_d.wait_ack = 1'b0;
            st_d.in_ack   = 1'b0;
            st_d.oe       = 1'b0;
            st_d.ptr      = '0;
        end else if (active) begin
            if (st_q.in_ack) begin
                if (scl_fall) begin
                    st_d.in_ack = 1'b0;
                    st_d.oe     = 1'b0;
                    st_d.phase  = phase_after(st_q.phase);
                end
            end else if (st_q.wait_ack) begin
                if (scl_fall) begin
                    st_d.wait_ack = 1'b0;
                    st_d.in_ack   = 1'b1;
                    st_d.oe       = 1'b1;
                end
            end else if (scl_rise) begin
                st_d.shreg = next_byte;
                if (st_q.bit_cnt == 3'd7) begin
                    st_d.bit_cnt = '0;
                    if (st_q.phase == PH_ADDR && next_byte != ADDR_WR) begin
                        st_d.phase = PH_SKIP;
                    end else begin
                        st_d.wait_ack = 1'b1;
                        if (st_q.phase == PH_DATA && st_q.ptr < PTR_END) begin
                            wr_en    = 1'b1;
                            st_d.ptr = st_q.ptr + 1'b1;
                        end
                    end
                end else begin
                    st_d.bit_cnt = st_q.bit_cnt + 3'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase    <= PH_IDLE;
            st_q.bit_cnt  <= '0;
            st_q.shreg    <= '0;
            st_q.wait_ack <= 1'b0;
            st_q.in_ack   <= 1'b0;
            st_q.oe       <= 1'b0;
            st_q.ptr      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe = st_q.oe;
    assign phase  = st_q.phase;
    assign ptr    = st_q.ptr;

endmodule

// File: rtl/clkcfg_regbank.sv
`timescale 1ns/1ps
module clkcfg_regbank
    import clkcfg_pkg::*;
#(
    parameter int unsigned NREG = 6,
    localparam int unsigned PW  = $clog2(NREG + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [PW-1:0]          wr_idx,
    input  logic [BYTE_W-1:0]      wr_data,
    output logic [NREG*BYTE_W-1:0] image
);
    logic [BYTE_W-1:0] bank_d [NREG];
    logic [BYTE_W-1:0] bank_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            bank_d[i] = bank_q[i];
            if (wr_en && wr_idx == PW'(i)) bank_d[i] = wr_data;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bank_q[g] <= reg_default(g);
            else        bank_q[g] <= bank_d[g];
        end
        assign image[g*BYTE_W +: BYTE_W] = bank_q[g];
    end

endmodule

// File: rtl/clkcfg_slave.sv
`timescale 1ns/1ps
module clkcfg_slave
    import clkcfg_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h69,
    parameter int unsigned NREG     = 6,
    parameter int unsigned STAGES   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    output logic [2:0]             aux_clk_en,
    output logic                   ssc_en,
    output logic [7:0]             sdram_clk_en,
    output logic [7:0]             pci_clk_en,
    output logic                   spread_center,
    output logic [NREG*BYTE_W-1:0] cfg_image
);
    localparam int unsigned PW = $clog2(NREG + 1);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    phase_e            phase;
    logic [PW-1:0]     ptr;
    logic              wr_en;
    logic [PW-1:0]     wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic              scl_level_unused;

    clkcfg_sync #(.STAGES(STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign scl_level_unused = scl_s;

    clkcfg_bus_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .phase     (phase),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    clkcfg_regbank #(.NREG(NREG)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .image   (cfg_image)
    );

    assign aux_clk_en    = cfg_image[2:0];
    assign ssc_en        = cfg_image[3];
    assign sdram_clk_en  = cfg_image[15:8];
    assign pci_clk_en    = cfg_image[23:16];
    assign spread_center = cfg_image[47];

endmodule

// File: rtl/clkcfg_slave_chk.sv
`timescale 1ns/1ps
module clkcfg_slave_chk
    import clkcfg_pkg::*;
#(
    parameter int unsigned NREG = 6,
    localparam int unsigned PW  = $clog2(NREG + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sda_oe,
    input logic                   scl_fall,
    input logic                   start_det,
    input logic                   stop_det,
    input phase_e                 phase,
    input logic [PW-1:0]          ptr,
    input logic [NREG*BYTE_W-1:0] cfg_image
);
    AST_ACK_ON_SCL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall)); // R3

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det)); // R3

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SKIP) |-> !sda_oe); // R4

    AST_WRITE_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_image) |-> ($past(phase) == PH_DATA)); // R5

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PW'(NREG)); // R7

    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_det) |-> (phase == PH_ADDR && !sda_oe)); // R2

    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> (phase == PH_IDLE && !sda_oe)); // R2

endmodule

bind clkcfg_slave clkcfg_slave_chk #(.NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .phase     (phase),
    .ptr       (ptr),
    .cfg_image (cfg_image)
);

// File: tb/clkcfg_slave_bench.sv
`timescale 1ns/1ps
module clkcfg_slave_bench;
    localparam logic [6:0] DEV = 7'h69;
    localparam int H  = 12;
    localparam int NV = 6;
    localparam logic [47:0] DEFAULTS = 48'h00_00_00_FE_FF_07;

    // {addr[6:0], rw, ndata[7:0], byte0..byte6}
    localparam logic [71:0] VECS [NV] = '{
        {7'h69, 1'b0, 8'd3, 56'h12_34_56_00_00_00_00},
        {7'h69, 1'b0, 8'd6, 56'h8F_AA_55_C3_3C_80_00},
        {7'h68, 1'b0, 8'd2, 56'h00_00_00_00_00_00_00},
        {7'h69, 1'b1, 8'd2, 56'h11_11_00_00_00_00_00},
        {7'h69, 1'b0, 8'd7, 56'h07_FF_FE_11_22_01_99},
        {7'h69, 1'b0, 8'd1, 56'hF0_00_00_00_00_00_00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_drv = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [2:0]  aux_clk_en;
    logic        ssc_en;
    logic [7:0]  sdram_clk_en;
    logic [7:0]  pci_clk_en;
    logic        spread_center;
    logic [47:0] cfg_image;
    logic [47:0] model;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;
    assign sda_line = sda_drv & ~sda_oe;

    clkcfg_slave #(.DEV_ADDR(DEV)) u_clkcfg_slave (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl),
        .sda_i         (sda_line),
        .sda_oe        (sda_oe),
        .aux_clk_en    (aux_clk_en),
        .ssc_en        (ssc_en),
        .sdram_clk_en  (sdram_clk_en),
        .pci_clk_en    (pci_clk_en),
        .spread_center (spread_center),
        .cfg_image     (cfg_image)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; hw(H);
        scl = 1'b1;     hw(H);
        sda_drv = 1'b0; hw(H);
        scl = 1'b0;     hw(H);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; hw(H);
        scl = 1'b1;     hw(H);
        sda_drv = 1'b1; hw(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sda_drv = b[i]; hw(H);
            scl = 1'b1;     hw(H);
            scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic held);
        send_bits(b, 8);
        sda_drv = 1'b1; hw(H);
        scl = 1'b1;     hw(H/2);
        ack = sda_oe;   hw(H/2);
        scl = 1'b0;     hw(H/2);
        held = sda_oe;
    endtask

    task automatic check_outputs(input string req);
        chk(req, {61'd0, aux_clk_en}, {61'd0, model[2:0]});
        chk(req, {63'd0, ssc_en}, {63'd0, model[3]});
        chk(req, {56'd0, sdram_clk_en}, {56'd0, model[15:8]});
        chk(req, {56'd0, pci_clk_en}, {56'd0, model[23:16]});
        chk(req, {63'd0, spread_center}, {63'd0, model[47]});
    endtask

    initial begin
        logic ack;
        logic held;
        hw(5);
        chk("R1 reset image", {16'd0, cfg_image}, {16'd0, DEFAULTS});
        chk("R1 no ack in reset", {63'd0, sda_oe}, 64'd0);
        rst_n = 1'b1;
        hw(5);
        model = DEFAULTS;
        chk("R1 image after release", {16'd0, cfg_image}, {16'd0, model});
        check_outputs("R8 defaults");

        // table of transfers
        for (int v = 0; v < NV; v++) begin
            logic [71:0] vec;
            logic        hit;
            int          nd;
            vec = VECS[v];
            nd  = int'(vec[63:56]);
            hit = (vec[71:65] == DEV) && !vec[64];
            bus_start();
            send_byte(vec[71:64], ack, held);
            chk(hit ? "R3 address ack" : "R4 address nack", {63'd0, ack}, {63'd0, hit});
            chk("R3 ack released", {63'd0, held}, 64'd0);
            send_byte(8'hC7, ack, held);
            chk(hit ? "R5 command ack" : "R4 command ignored", {63'd0, ack}, {63'd0, hit});
            send_byte(vec[63:56], ack, held);
            chk(hit ? "R5 count ack" : "R4 count ignored", {63'd0, ack}, {63'd0, hit});
            if (hit) chk("R5 cmd/count no write", {16'd0, cfg_image}, {16'd0, model});
            for (int i = 0; i < nd; i++) begin
                logic [7:0] d;
                d = vec[55-8*i -: 8];
                send_byte(d, ack, held);
                chk(!hit ? "R4 data ignored" : (i >= 6 ? "R7 extra ack" : "R6 data ack"),
                    {63'd0, ack}, {63'd0, hit});
                if (hit && i < 6) model[8*i +: 8] = d;
            end
            bus_stop();
            hw(6);
            chk(hit ? (nd > 6 ? "R7 image" : "R6 image") : "R4 image unchanged",
                {16'd0, cfg_image}, {16'd0, model});
            check_outputs("R8 mapping");
        end

        // STOP in the middle of a data byte: nothing written
        bus_start();
        send_byte({DEV, 1'b0}, ack, held);
        send_byte(8'h00, ack, held);
        send_byte(8'h01, ack, held);
        send_bits(8'h3C, 4);
        hw(H);
        bus_stop();
        hw(6);
        chk("R2 stop aborts byte", {16'd0, cfg_image}, {16'd0, model});
        chk("R9 stop keeps values", {16'd0, cfg_image}, {16'd0, model});

        // repeated START after the command byte restarts the sequence
        bus_start();
        send_byte({DEV, 1'b0}, ack, held);
        send_byte(8'h00, ack, held);
        bus_start();
        send_byte({DEV, 1'b0}, ack, held);
        chk("R2 address after restart", {63'd0, ack}, 64'd1);
        send_byte(8'hAB, ack, held);
        send_byte(8'hCD, ack, held);
        chk("R2 restart kept values", {16'd0, cfg_image}, {16'd0, model});
        send_byte(8'h5A, ack, held);
        bus_stop();
        hw(6);
        model[7:0] = 8'h5A;
        chk("R2 restart writes reg0", {16'd0, cfg_image}, {16'd0, model});
        check_outputs("R8 after restart");

        // only the power-on reset reloads defaults
        rst_n = 1'b0;
        hw(4);
        rst_n = 1'b1;
        hw(4);
        model = DEFAULTS;
        chk("R9 reset reloads", {16'd0, cfg_image}, {16'd0, model});
        chk("R1 defaults again", {16'd0, cfg_image}, {16'd0, DEFAULTS});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule